// File: doc/BRIEF.md
# Serial Audio Link Power Sequencer

This block sits on the host side of a serial audio codec link and moves the link between running and low-power states. Software reaches it through a small word-addressed register port. It can request a shutdown, request a warm restart, allow or mask a wake interrupt, and read the codec readiness lines. The sequencer decides when each request takes effect. Shutdown removes the link enable at once. Frames are then counted on the frame strobe input, which first blanks out wake detection and later permits a restart. A warm restart drives the SYNC line high for a fixed number of clock cycles. It then waits for the codec bit clock to come back.

A wake event from the codec only raises a sticky interrupt flag. Restarting the link is always left to software. When the codec has been power-cycled, software can bring the link up by clearing the shutdown bit alone, without a SYNC pulse. Register contents are kept across the low-power state, except for the bits that the power-up path clears by design.

Register map (word index on `reg_addr`):
- index 0, global control: bit 29 = wake interrupt enable (RW), bit 28 = wake flag (write 1 to clear).
- index 2, status: bits 23:22 = codec ready (bit 22 primary, bit 23 secondary).
- index 3, link control: bit 18 = shutdown, bit 17 = warm restart.
- All other bits and index 1 read as zero.

Top module: `aclink_pwr_seq`

## Requirements
- R1: After reset, `link_en`=1, `link_ready`=0, `sync_out`=0, `wake_irq`=0, and every register reads zero.
- R2: Writing 1 to link-control bit 18 while the link is ready drops `link_en` and `link_ready` at the next clock edge. Bit 18 then reads 1.
- R3: Status bits 23:22 follow `codec_rdy[1:0]` after a two-flop synchroniser. In the start-up state, `link_ready` rises only once the primary ready line (`codec_rdy[0]`, status bit 22) is seen high.
- R4: Global bit 29 (wake interrupt enable) is writable and reads back. Hardware clears it when the link leaves the powered-down state.
- R5: A wake input seen before `GUARD_FRAMES` (2) frame strobes have passed since shutdown never sets the wake flag.
- R6: An accepted warm restart sets link-control bit 17. It drives `sync_out` high for exactly `SYNC_CYCLES` (4) clock cycles. When `bitclk_active` is then seen, it re-enables the link and clears bits 17 and 18.
- R7: Before `HOLDOFF_FRAMES` (6) frame strobes have passed since shutdown, a warm-restart write and a shutdown-clear write are both ignored: `sync_out` stays low, `link_en` stays low, and the control bits do not change.
- R8: Once the guard has passed, a high wake input with the enable set raises `wake_irq` and global bit 28. The link stays down (`link_en`=0, `sync_out`=0). With the enable clear, no flag is raised.
- R9: Writing 1 to global bit 28 clears the wake flag and `wake_irq`. Writing 0 there leaves the flag unchanged.
- R10: While powered down, the wake enable and shutdown bits keep their values.
- R11: Clearing bit 18 after the holdoff restarts the link (`link_en`=1 at the next edge) with no SYNC pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| frame_strobe | input | 1 | One-cycle pulse per audio frame |
| bitclk_active | input | 1 | Codec bit clock detected running (asynchronous) |
| wake_in | input | 1 | Wake request from the codec data line (asynchronous) |
| codec_rdy | input | 2 | Codec ready lines, [0] primary (asynchronous) |
| link_en | output | 1 | Link framing enabled |
| link_ready | output | 1 | Link up and primary codec ready |
| sync_out | output | 1 | SYNC line drive for warm restart |
| wake_irq | output | 1 | Sticky wake interrupt |

## Verification
A wrong state or a wrong frame count shows up at the ports through timing. A warm-restart write is accepted or refused, and `sync_out` shows this at the very next clock edge. A wake pulse either reaches `wake_irq` within three edges or never does, depending on whether the guard has closed. A corrupted SYNC counter changes the number of high cycles on `sync_out`. A missed hardware clear becomes visible on the first register read after power-up. The bench moves the strobe count randomly around both frame limits so that an off-by-one in either window changes an observed output.

// File: rtl/aclink_pwr_pkg.sv
package aclink_pwr_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE     = 3'd0,
    ST_GUARD      = 3'd1,
    ST_SHUTDOWN   = 3'd2,
    ST_WARM_RESET = 3'd3,
    ST_WAIT_READY = 3'd4
  } pwr_state_t;

  localparam int REG_W      = 32;
  localparam logic [1:0] ADDR_GLB  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  localparam int IE_BIT     = 29;
  localparam int FLAG_BIT   = 28;
  localparam int RDY_LO_BIT = 22;
  localparam int SHUT_BIT   = 18;
  localparam int WARM_BIT   = 17;
endpackage

// File: rtl/aclink_sync2.sv
module aclink_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int GUARD_FRAMES   = 2,
  parameter int HOLDOFF_FRAMES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  output logic guard_done,
  output logic hold_done
);
  localparam int CNT_W = $clog2(HOLDOFF_FRAMES + 1);
  localparam logic [CNT_W-1:0] GUARD_LIM = CNT_W'(GUARD_FRAMES);
  localparam logic [CNT_W-1:0] HOLD_LIM  = CNT_W'(HOLDOFF_FRAMES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (strobe && cnt != HOLD_LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign guard_done = (cnt >= GUARD_LIM);
  assign hold_done  = (cnt >= HOLD_LIM);
endmodule

// File: rtl/aclink_sync_pulse.sv
module aclink_sync_pulse #(
  parameter int SYNC_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sync_q
);
  localparam int PW = $clog2(SYNC_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(SYNC_CYCLES - 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      sync_q <= 1'b0;
    end else if (start) begin
      left   <= LOAD;
      sync_q <= 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      sync_q <= 1'b0;
    end
  end
endmodule

// File: rtl/aclink_pwr_seq.sv
module aclink_pwr_seq
  import aclink_pwr_pkg::*;
#(
  parameter int GUARD_FRAMES   = 2,
  parameter int HOLDOFF_FRAMES = 6,
  parameter int SYNC_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              frame_strobe,
  input  logic              bitclk_active,
  input  logic              wake_in,
  input  logic [1:0]        codec_rdy,
  output logic              link_en,
  output logic              link_ready,
  output logic              sync_out,
  output logic              wake_irq
);
  pwr_state_t state_q, state_d;
  logic ie_q, flag_q, shut_q, warm_q;
  logic wake_s, bclk_s;
  logic [1:0] rdy_s;
  logic guard_done, hold_done, frame_clr;
  logic pulse_start, sync_busy;
  logic ctl_wr, glb_wr, entering_up;
  logic [REG_W-1:0] rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:30], reg_wdata[27:19], reg_wdata[16:0]};

  aclink_sync2 #(.W(4)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({codec_rdy, bitclk_active, wake_in}),
    .q   ({rdy_s, bclk_s, wake_s})
  );

  assign frame_clr = !(state_q == ST_GUARD || state_q == ST_SHUTDOWN);

  aclink_frame_timer #(
    .GUARD_FRAMES   (GUARD_FRAMES),
    .HOLDOFF_FRAMES (HOLDOFF_FRAMES)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .clr        (frame_clr),
    .strobe     (frame_strobe),
    .guard_done (guard_done),
    .hold_done  (hold_done)
  );

  aclink_sync_pulse #(.SYNC_CYCLES(SYNC_CYCLES)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .start  (pulse_start),
    .sync_q (sync_busy)
  );

  assign ctl_wr = reg_wr && (reg_addr == ADDR_CTL);
  assign glb_wr = reg_wr && (reg_addr == ADDR_GLB);

  always_comb begin
    state_d     = state_q;
    pulse_start = 1'b0;
    case (state_q)
      ST_ACTIVE: begin
        if (ctl_wr && reg_wdata[SHUT_BIT]) state_d = ST_GUARD;
      end
      ST_GUARD: begin
        if (guard_done) state_d = ST_SHUTDOWN;
      end
      ST_SHUTDOWN: begin
        if (ctl_wr && hold_done) begin
          if (reg_wdata[WARM_BIT]) begin
            state_d     = ST_WARM_RESET;
            pulse_start = 1'b1;
          end else if (!reg_wdata[SHUT_BIT]) begin
            state_d = ST_WAIT_READY;
          end
        end
      end
      ST_WARM_RESET: begin
        if (!sync_busy && bclk_s) state_d = ST_WAIT_READY;
      end
      ST_WAIT_READY: begin
        if (rdy_s[0]) state_d = ST_ACTIVE;
      end
      default: state_d = ST_WAIT_READY;
    endcase
  end

  assign entering_up = (state_d == ST_WAIT_READY) && (state_q != ST_WAIT_READY);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_GLB: begin
        rd_mux[IE_BIT]   = ie_q;
        rd_mux[FLAG_BIT] = flag_q;
      end
      ADDR_STAT: rd_mux[RDY_LO_BIT+1:RDY_LO_BIT] = rdy_s;
      ADDR_CTL: begin
        rd_mux[SHUT_BIT] = shut_q;
        rd_mux[WARM_BIT] = warm_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_WAIT_READY;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      shut_q     <= 1'b0;
      warm_q     <= 1'b0;
      link_en    <= 1'b1;
      link_ready <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      state_q <= state_d;
      if (glb_wr) ie_q <= reg_wdata[IE_BIT];
      if (glb_wr && reg_wdata[FLAG_BIT]) flag_q <= 1'b0;
      if (state_q == ST_SHUTDOWN && ie_q && wake_s) flag_q <= 1'b1;
      if (state_q == ST_ACTIVE && state_d == ST_GUARD) shut_q <= 1'b1;
      if (pulse_start) warm_q <= 1'b1;
      if (entering_up) begin
        warm_q <= 1'b0;
        shut_q <= 1'b0;
        ie_q   <= 1'b0;
      end
      link_en    <= (state_d == ST_ACTIVE) || (state_d == ST_WAIT_READY);
      link_ready <= (state_d == ST_ACTIVE);
      reg_rdata  <= rd_mux;
    end
  end

  assign sync_out = sync_busy;
  assign wake_irq = flag_q;
endmodule

// File: rtl/aclink_pwr_seq_chk.sv
module aclink_pwr_seq_chk
  import aclink_pwr_pkg::*;
#(
  parameter int SYNC_CYCLES = 4
) (
  input logic       clk,
  input logic       rst,
  input pwr_state_t state_q,
  input logic       flag_q,
  input logic       ie_q,
  input logic       hold_done,
  input logic       reg_wr,
  input logic       sync_out,
  input logic       link_en
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (sync_out) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  assert_guard_masks_wake_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(state_q) == ST_SHUTDOWN);

  assert_ie_cleared_on_up_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_READY && $past(state_q) != ST_WAIT_READY) |-> !ie_q);

  assert_holdoff_before_warm_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM_RESET && $past(state_q) == ST_SHUTDOWN) |-> $past(hold_done));

  assert_sync_only_in_warm_R6: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> state_q == ST_WARM_RESET);

  assert_sync_width_R6: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> hi_cnt < 16'(SYNC_CYCLES));

  assert_wake_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SHUTDOWN && $past(state_q) == ST_SHUTDOWN) |-> $past(reg_wr));

  assert_link_down_in_shutdown_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GUARD || state_q == ST_SHUTDOWN) |-> !link_en);
endmodule

bind aclink_pwr_seq aclink_pwr_seq_chk #(.SYNC_CYCLES(SYNC_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .state_q   (state_q),
  .flag_q    (flag_q),
  .ie_q      (ie_q),
  .hold_done (hold_done),
  .reg_wr    (reg_wr),
  .sync_out  (sync_out),
  .link_en   (link_en)
);

// File: tb/aclink_pwr_seq_tb.sv
module aclink_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD = 2;
  localparam int HOLD  = 6;
  localparam int SYNCN = 4;
  localparam logic [1:0] A_GLB = 2'd0, A_STAT = 2'd2, A_CTL = 2'd3;
  localparam logic [31:0] B_IE = 32'h1 << 29, B_FLAG = 32'h1 << 28;
  localparam logic [31:0] B_SHUT = 32'h1 << 18, B_WARM = 32'h1 << 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic frame_strobe = 1'b0, bitclk_active = 1'b1, wake_in = 1'b0;
  logic [1:0] codec_rdy = 2'b00;
  logic link_en, link_ready, sync_out, wake_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  aclink_pwr_seq dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_strobe(frame_strobe),
    .bitclk_active(bitclk_active), .wake_in(wake_in), .codec_rdy(codec_rdy),
    .link_en(link_en), .link_ready(link_ready), .sync_out(sync_out), .wake_irq(wake_irq)
  );

  function automatic bit exp_accept(int k);
    return k >= HOLD;
  endfunction

  function automatic bit exp_irq(bit ie, int k);
    return ie && (k >= GUARD);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a);
    reg_addr = a;
    tick();
    rv = reg_rdata;
  endtask

  task automatic strobe();
    frame_strobe = 1'b1; tick(); frame_strobe = 1'b0; tick(2);
  endtask

  task automatic wake_pulse();
    wake_in = 1'b1; tick(4); wake_in = 1'b0; tick(4);
  endtask

  task automatic shutdown();
    wr(A_CTL, B_SHUT);
    bitclk_active = 1'b0;
    codec_rdy = 2'b00;
  endtask

  task automatic bring_up();
    tick(SYNCN + 2);
    bitclk_active = 1'b1;
    tick(5);
    codec_rdy = 2'b11;
    tick(5);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 link_en", link_en, 1);
    chk("R1 link_ready", link_ready, 0);
    chk("R1 sync", sync_out, 0);
    chk("R1 irq", wake_irq, 0);
    rd(A_CTL); chk("R1 ctl", rv, 0);
    rd(A_GLB); chk("R1 glb", rv, 0);

    // R3 secondary only does not make the link ready
    codec_rdy = 2'b10; tick(5);
    chk("R3 not ready on secondary", link_ready, 0);
    rd(A_STAT); chk("R3 status bits", rv, 32'h2 << 22);
    codec_rdy = 2'b11; tick(5);
    chk("R3 ready on primary", link_ready, 1);

    // R4 enable writable
    wr(A_GLB, B_IE);
    rd(A_GLB); chk("R4 ie readback", rv, B_IE);

    // R2 shutdown
    shutdown();
    chk("R2 link_en low", link_en, 0);
    chk("R2 link_ready low", link_ready, 0);
    rd(A_CTL); chk("R2 shut bit", rv, B_SHUT);
    rd(A_GLB); chk("R10 ie kept", rv, B_IE);

    // R5 guard masking
    wake_pulse(); chk("R5 masked at 0 frames", wake_irq, 0);
    strobe(); wake_pulse(); chk("R5 masked at 1 frame", wake_irq, 0);
    strobe(); tick(2);

    // R7 early restart ignored
    wr(A_CTL, B_SHUT | B_WARM);
    chk("R7 no sync", sync_out, 0);
    tick(3); chk("R7 no sync later", sync_out, 0);
    rd(A_CTL); chk("R7 ctl unchanged", rv, B_SHUT);
    wr(A_CTL, 0); tick(2);
    chk("R7 shut clear ignored", link_en, 0);
    rd(A_CTL); chk("R10 shut kept", rv, B_SHUT);

    // R8 wake after guard
    wake_pulse();
    chk("R8 irq", wake_irq, 1);
    chk("R8 link stays down", link_en, 0);
    chk("R8 no sync", sync_out, 0);
    rd(A_GLB); chk("R8 flag bit", rv, B_IE | B_FLAG);

    // R9 write-one-to-clear
    wr(A_GLB, B_IE); tick();
    chk("R9 write 0 keeps flag", wake_irq, 1);
    wr(A_GLB, B_IE | B_FLAG); tick();
    chk("R9 write 1 clears flag", wake_irq, 0);

    // R6 warm restart
    repeat (HOLD - GUARD) strobe();
    wr(A_CTL, B_SHUT | B_WARM);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (i == 1) begin
        rd(A_CTL); chk("R6 warm bit set", rv, B_SHUT | B_WARM);
        cnt += int'(sync_out);
      end else begin
        cnt += int'(sync_out);
        tick();
      end
    end
    chk("R6 sync width", cnt, SYNCN);
    chk("R6 link down before bitclk", link_en, 0);
    bitclk_active = 1'b1; tick(5);
    chk("R6 link_en back", link_en, 1);
    chk("R6 not ready yet", link_ready, 0);
    rd(A_CTL); chk("R6 ctl cleared", rv, 0);
    rd(A_GLB); chk("R4 ie auto-cleared", rv, 0);
    codec_rdy = 2'b11; tick(5);
    chk("R6 ready", link_ready, 1);

    // R11 cold restart
    shutdown();
    repeat (HOLD) strobe();
    wr(A_CTL, 0);
    chk("R11 link_en", link_en, 1);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin cnt += int'(sync_out); tick(); end
    chk("R11 no sync", cnt, 0);
    rd(A_CTL); chk("R11 ctl", rv, 0);
    codec_rdy = 2'b11; tick(5);

    // Random mix around both frame limits
    for (int it = 0; it < 16; it++) begin
      bit ie;
      int k;
      ie = 1'($urandom % 2);
      k  = int'($urandom_range(0, 8));
      wr(A_GLB, ie ? B_IE : 32'h0);
      shutdown();
      repeat (k) strobe();
      wake_pulse();
      chk("R5/R8 random irq", wake_irq, exp_irq(ie, k));
      wr(A_GLB, B_FLAG);
      wr(A_CTL, B_SHUT | B_WARM);
      chk("R7 random accept", sync_out, exp_accept(k));
      if (!exp_accept(k)) begin
        repeat (HOLD - k) strobe();
        wr(A_CTL, B_SHUT | B_WARM);
        chk("R6 random accept after holdoff", sync_out, 1);
      end
      bring_up();
      chk("R6 random up", link_ready, 1);
    end

    report();
  end
endmodule